// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

The block holds a set of independent down-counters reached through a zero-wait-state APB slave port. Each channel has its own 16-byte register window. A window holds a reload value, the live count, a three-bit control word and an acknowledge location. Software reads that acknowledge location to retire the channel's interrupt. One shared window gathers the raw expiry flags, the same flags after masking, and a fixed version word. Each channel drives its own level interrupt line, which stays high until the channel's expiry flag is cleared.

Each channel is a two-state machine. In ST_OFF the counter holds. The START transition (control written with enable set) loads the counter from the reload register and enters ST_RUN. In ST_RUN the COUNT step lowers the count by one on each clock. The RELOAD step fires on the clock after the count has reached zero: it refills the counter, with the reload value in periodic mode and with all ones in free-running mode, and it sets the expiry flag. The STOP transition (control written with enable clear) returns the channel to ST_OFF. A channel with reload value L therefore expires every L+1 clocks. With all ones as its reload, a free-running channel serves as a time base that software can read.

Top module: `tmr_bank`

## Requirements
- R1: After reset every reload, count, control and flag register reads 0, and every interrupt output is low.
- R2: Channel n sits at byte offset 16*n: reload at +0, live count at +4, control at +8 (bit 0 enable, bit 1 periodic when 1, bit 2 mask when 1), acknowledge at +12. Writing control with enable 1 while the channel is stopped loads the count from the reload register on that edge. The count then drops by one on each clock.
- R3: In periodic mode (control bit 1 = 1), a running count of zero is refilled from the reload register on the next clock.
- R4: In free-running mode (control bit 1 = 0), a running count of zero is refilled with 0xFFFFFFFF on the next clock.
- R5: A channel's expiry sets bit n of the raw flag register (offset 0x80+4) whatever its mask bit is. The interrupt output n and bit n of the masked flag register (offset 0x80) equal that raw bit while the mask bit is 0, and are 0 while the mask bit is 1.
- R6: A read of channel n's acknowledge location returns 0 and clears raw bit n and interrupt n. Other channels' bits are left alone. An expiry on the same edge wins over the clear.
- R7: A stopped channel holds its count, and its raw bit changes only through an acknowledge read. A control write that clears enable stops the channel on that edge, with no decrement and no expiry.
- R8: A reload-register write while the channel runs leaves the live count untouched. The new value is used from the next refill onward.
- R9: Writes to the live count, the flag registers and the version word (offset 0x80+8) are ignored, and the version word always reads its parameter value. Reads of unmapped offsets return 0.
- R10: The slave never inserts wait states: pready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, also the counting clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | AW (8) | APB byte address |
| pwdata | input | W (32) | APB write data |
| prdata | output | W (32) | APB read data |
| pready | output | 1 | APB ready, always 1 |
| irq | output | N (8) | Per-channel interrupt, raw flag gated by mask |

## Verification
The bench models the count as a function of the clocks elapsed since START. It samples across the periodic wrap, where a design that refills one clock early or late yields a period other than L+1, and across the free-running wrap, where a design that reuses the reload value returns a small number instead of 0xFFFFFFFF. A masked channel is driven to expire. This catches a design that gates the raw flag instead of only the output, which would leave the raw bit at 0. An acknowledge read is then checked for clearing exactly one channel's bit. Stop-and-hold, restart reloading, and reload writes during a run are also targeted: a design that keeps counting when stopped, or that copies the reload value straight into the live count, reads back the wrong value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } tmr_state_e;

    // control word bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_PER = 1;
    localparam int CTL_MSK = 2;
    localparam int CTL_W   = 3;

    // word index inside a channel window
    localparam int REG_LOAD = 0;
    localparam int REG_CUR  = 1;
    localparam int REG_CTL  = 2;
    localparam int REG_EOI  = 3;

    // word index inside the shared window
    localparam int SH_MIS = 0;
    localparam int SH_RAW = 1;
    localparam int SH_VER = 2;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic             ctl_we,
    input  logic             eoi_rd,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     load_q,
    output logic [W-1:0]     cnt_q,
    output logic [CTL_W-1:0] ctl_q,
    output logic             raw_q,
    output logic             irq_o
);
    tmr_state_e st_q, st_d;
    logic per_q, msk_q;
    logic start, keep_run, expire;

    // next-state logic: START / STOP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: if (ctl_we && wdata[CTL_EN])  st_d = ST_RUN;
            ST_RUN: if (ctl_we && !wdata[CTL_EN]) st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    assign start    = (st_q == ST_OFF) && (st_d == ST_RUN);
    assign keep_run = (st_q == ST_RUN) && (st_d == ST_RUN);
    assign expire   = keep_run && (cnt_q == '0);

    // datapath outputs: COUNT / RELOAD, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            cnt_q  <= '0;
            per_q  <= 1'b0;
            msk_q  <= 1'b0;
            raw_q  <= 1'b0;
        end else begin
            if (load_we) load_q <= wdata;
            if (ctl_we) begin
                per_q <= wdata[CTL_PER];
                msk_q <= wdata[CTL_MSK];
            end
            if (start)         cnt_q <= load_q;
            else if (expire)   cnt_q <= per_q ? load_q : '1;
            else if (keep_run) cnt_q <= cnt_q - 1'b1;
            if (expire)      raw_q <= 1'b1;
            else if (eoi_rd) raw_q <= 1'b0;
        end
    end

    assign ctl_q = {msk_q, per_q, (st_q == ST_RUN)};
    assign irq_o = raw_q & ~msk_q;
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int          N       = 8,
    parameter int          W       = 32,
    parameter int          AW      = 8,
    parameter int          SLG     = 4,
    parameter logic [31:0] VERSION = 32'h5449_0100
) (
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [AW-1:0]             paddr,
    input  logic [N-1:0][W-1:0]       load_q,
    input  logic [N-1:0][W-1:0]       cnt_q,
    input  logic [N-1:0][CTL_W-1:0]   ctl_q,
    input  logic [N-1:0]              raw_q,
    input  logic [N-1:0]              msk_q,
    output logic [N-1:0]              load_we,
    output logic [N-1:0]              ctl_we,
    output logic [N-1:0]              eoi_rd,
    output logic [W-1:0]              prdata
);
    localparam int WINW = AW - SLG;
    localparam int WRDW = SLG - 2;
    localparam int IDXW = $clog2(N);

    logic            acc_wr, acc_rd;
    logic [WINW-1:0] win;
    logic [WRDW-1:0] wrd;
    logic [IDXW-1:0] idx;
    logic            unused_lsb;

    assign acc_wr     = psel & penable & pwrite;
    assign acc_rd     = psel & penable & ~pwrite;
    assign win        = paddr[AW-1:SLG];
    assign wrd        = paddr[SLG-1:2];
    assign idx        = win[IDXW-1:0];
    assign unused_lsb = ^paddr[1:0];

    generate
        for (genvar i = 0; i < N; i++) begin : g_dec
            logic hit;
            assign hit        = (win == WINW'(i));
            assign load_we[i] = acc_wr & hit & (wrd == WRDW'(REG_LOAD));
            assign ctl_we[i]  = acc_wr & hit & (wrd == WRDW'(REG_CTL));
            assign eoi_rd[i]  = acc_rd & hit & (wrd == WRDW'(REG_EOI));
        end
    endgenerate

    always_comb begin
        prdata = '0;
        if (win < WINW'(N)) begin
            case (wrd)
                WRDW'(REG_LOAD): prdata = load_q[idx];
                WRDW'(REG_CUR):  prdata = cnt_q[idx];
                WRDW'(REG_CTL):  prdata = W'(ctl_q[idx]);
                default:         prdata = '0;
            endcase
        end else if (win == WINW'(N)) begin
            case (wrd)
                WRDW'(SH_MIS): prdata = W'(raw_q & ~msk_q);
                WRDW'(SH_RAW): prdata = W'(raw_q);
                WRDW'(SH_VER): prdata = W'(VERSION);
                default:       prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int          N       = 8,
    parameter int          W       = 32,
    parameter int          AW      = 8,
    parameter int          SLG     = 4,
    parameter logic [31:0] VERSION = 32'h5449_0100
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [W-1:0]  pwdata,
    output logic [W-1:0]  prdata,
    output logic          pready,
    output logic [N-1:0]  irq
);
    logic [N-1:0][W-1:0]     ch_load, ch_cnt;
    logic [N-1:0][CTL_W-1:0] ch_ctl;
    logic [N-1:0]            ch_raw, ch_msk;
    logic [N-1:0]            ld_we, ctl_we, eoi_rd;

    assign pready = 1'b1;

    tmr_regif #(
        .N(N), .W(W), .AW(AW), .SLG(SLG), .VERSION(VERSION)
    ) u_regif (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .load_q(ch_load), .cnt_q(ch_cnt), .ctl_q(ch_ctl),
        .raw_q(ch_raw), .msk_q(ch_msk),
        .load_we(ld_we), .ctl_we(ctl_we), .eoi_rd(eoi_rd),
        .prdata(prdata)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            tmr_chan #(.W(W)) u_ch (
                .clk(pclk), .rst_n(presetn),
                .load_we(ld_we[i]), .ctl_we(ctl_we[i]), .eoi_rd(eoi_rd[i]),
                .wdata(pwdata),
                .load_q(ch_load[i]), .cnt_q(ch_cnt[i]), .ctl_q(ch_ctl[i]),
                .raw_q(ch_raw[i]), .irq_o(irq[i])
            );
            assign ch_msk[i] = ch_ctl[i][CTL_MSK];
        end
    endgenerate
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_bit,
    input logic [N-1:0][W-1:0]     ch_cnt,
    input logic [N-1:0][W-1:0]     ch_load,
    input logic [N-1:0][CTL_W-1:0] ch_ctl,
    input logic [N-1:0]            ch_raw,
    input logic [N-1:0]            eoi_rd,
    input logic [N-1:0]            ctl_we
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_a
            logic run, per, zero, unused_msk;
            assign run        = ch_ctl[i][CTL_EN];
            assign per        = ch_ctl[i][CTL_PER];
            assign zero       = (ch_cnt[i] == '0);
            assign unused_msk = ch_ctl[i][CTL_MSK];

            AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && ctl_we[i] && en_bit) |=> (run && ch_cnt[i] == $past(ch_load[i]))); // R2
            AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
                (run && !zero && !ctl_we[i]) |=> (ch_cnt[i] == $past(ch_cnt[i]) - W'(1))); // R2
            AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (run && zero && per && !ctl_we[i]) |=> (ch_cnt[i] == $past(ch_load[i]))); // R3
            AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (run && zero && !per && !ctl_we[i]) |=> (&ch_cnt[i])); // R4
            AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (run && zero && !ctl_we[i]) |=> ch_raw[i]); // R5
            AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (eoi_rd[i] && !(run && zero)) |=> !ch_raw[i]); // R6
            AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !ctl_we[i]) |=> $stable(ch_cnt[i])); // R7
            AST_HOLD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
                (!run && !eoi_rd[i]) |=> $stable(ch_raw[i])); // R7
        end
    endgenerate
endmodule

bind tmr_bank tmr_bank_chk #(.N(N), .W(W)) u_chk (
    .clk(pclk), .rst_n(presetn), .en_bit(pwdata[0]),
    .ch_cnt(ch_cnt), .ch_load(ch_load), .ch_ctl(ch_ctl),
    .ch_raw(ch_raw), .eoi_rd(eoi_rd), .ctl_we(ctl_we)
);

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;
    localparam logic [31:0] VER = 32'h5449_0100;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [7:0]  irq;

    int checks = 0, fails = 0;
    int cyc = 0, last_wr_cyc = 0, rd_cyc = 0;
    logic rd_ready;

    tmr_bank #(.VERSION(VER)) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .irq(irq)
    );

    always #2 pclk = ~pclk;   // 250 MHz
    always @(posedge pclk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
        last_wr_cyc = cyc;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1;
        #1; d = prdata; rd_ready = pready; rd_cyc = cyc;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    // expected live count e clocks after START with reload l
    function automatic logic [31:0] mdl(input int l, input int e, input bit per);
        if (e <= l) return 32'(l - e);
        if (per)    return 32'(l - ((e - l - 1) % (l + 1)));
        return 32'hFFFF_FFFF - 32'(e - l - 1);
    endfunction

    // {write, req, addr, wdata, expected}
    localparam int NV = 16;
    localparam logic [76:0] VEC [NV] = '{
        {1'b0, 4'd1, 8'h00, 32'h0,    32'h0},     // R1 reload reset
        {1'b0, 4'd1, 8'h84, 32'h0,    32'h0},     // R1 raw flags reset
        {1'b0, 4'd9, 8'h88, 32'h0,    VER},       // R9 version
        {1'b1, 4'd2, 8'h00, 32'h1234, 32'h0},
        {1'b0, 4'd2, 8'h00, 32'h0,    32'h1234},  // R2 reload readback
        {1'b1, 4'd9, 8'h14, 32'hFF,   32'h0},
        {1'b0, 4'd9, 8'h14, 32'h0,    32'h0},     // R9 count write ignored
        {1'b1, 4'd9, 8'h88, 32'h0,    32'h0},
        {1'b0, 4'd9, 8'h88, 32'h0,    VER},       // R9 version write ignored
        {1'b1, 4'd9, 8'h84, 32'hFF,   32'h0},
        {1'b0, 4'd9, 8'h84, 32'h0,    32'h0},     // R9 raw write ignored
        {1'b0, 4'd9, 8'hC0, 32'h0,    32'h0},     // R9 unmapped window
        {1'b0, 4'd9, 8'h8C, 32'h0,    32'h0},     // R9 unmapped shared word
        {1'b1, 4'd2, 8'h78, 32'h6,    32'h0},
        {1'b0, 4'd2, 8'h78, 32'h0,    32'h6},     // R2 control readback
        {1'b0, 4'd7, 8'h04, 32'h0,    32'h0}      // R7 stopped count holds
    };

    initial begin : watchdog
        #400_000;
        fails++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int en2, en3, en4, en5, dis4, k;
        logic [31:0] held;

        repeat (5) @(negedge pclk);
        presetn = 1;
        @(negedge pclk);
        chk("R1 irq", 32'(irq), 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][76]) wr(VEC[v][71:64], VEC[v][63:32]);
            else begin
                rd(VEC[v][71:64], d);
                chk($sformatf("R%0d vec%0d", VEC[v][75:72], v), d, VEC[v][31:0]);
            end
        end
        chk("R10 pready", 32'(rd_ready), 32'h1);

        // periodic channel 2, reload 5
        wr(8'h20, 32'd5); wr(8'h28, 32'h3); en2 = last_wr_cyc;
        rd(8'h24, d); chk("R2 count", d, mdl(5, rd_cyc - en2, 1));
        for (int j = 0; j < 4; j++) begin
            rd(8'h24, d); chk("R3 periodic", d, mdl(5, rd_cyc - en2, 1));
        end
        rd(8'h84, d); chk("R5 raw2", 32'(d[2]), 32'h1);
        @(negedge pclk); chk("R5 irq2", 32'(irq[2]), 32'h1);

        // masked periodic channel 3, reload 40
        wr(8'h30, 32'd40); wr(8'h38, 32'h7); en3 = last_wr_cyc;
        while (cyc - en3 < 44) @(negedge pclk);
        rd(8'h84, d); chk("R5 raw3 masked", 32'(d[3]), 32'h1);
        chk("R5 irq3 masked", 32'(irq[3]), 32'h0);
        rd(8'h80, d); chk("R5 masked flags", d & 32'hC, 32'h4);
        rd(8'h3C, d); chk("R6 ack data", d, 32'h0);
        rd(8'h84, d); chk("R6 raw3 cleared", 32'(d[3]), 32'h0);
        chk("R6 raw2 kept", 32'(d[2]), 32'h1);

        // free-running channel 4, reload 3
        wr(8'h40, 32'd3); wr(8'h48, 32'h1); en4 = last_wr_cyc;
        repeat (6) @(negedge pclk);
        rd(8'h44, d); chk("R4 free wrap", d, mdl(3, rd_cyc - en4, 0));
        wr(8'h48, 32'h0); dis4 = last_wr_cyc;
        held = mdl(3, dis4 - 1 - en4, 0);
        rd(8'h44, d); chk("R7 stop", d, held);
        repeat (10) @(negedge pclk);
        rd(8'h44, d); chk("R7 hold", d, held);
        rd(8'h84, d); chk("R7 raw4 held", 32'(d[4]), 32'h1);
        wr(8'h48, 32'h1); en4 = last_wr_cyc;
        rd(8'h44, d); chk("R2 restart", d, mdl(3, rd_cyc - en4, 0));

        // channel 5 reload changed while running
        wr(8'h50, 32'd100); wr(8'h58, 32'h3); en5 = last_wr_cyc;
        wr(8'h50, 32'd2);
        rd(8'h54, d); chk("R8 live kept", d, mdl(100, rd_cyc - en5, 1));
        while (cyc - en5 < 110) @(negedge pclk);
        rd(8'h54, d);
        k = rd_cyc - en5;
        chk("R8 new reload", d, 32'(2 - ((k - 101) % 3)));
        rd(8'h50, d); chk("R8 reload reg", d, 32'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule